// File: doc/BRIEF.md
# Indirect PHY Delay Register Port

This block lets host software reach a small bank of 8-bit PHY delay registers through one 32-bit register in the host register space. The host puts the target register index and the write byte into that word, then pulses a write or read strobe bit by writing the word again. The port turns each strobe rising edge into one access on an internal delay register file. The read result and an acknowledge flag come back in the same word.

There is one delay register for each bus timing mode, nine in all, at indices 0 to 8. Index 0 is SD high-speed and 1 is SD default. Indices 2 to 5 are the four UHS modes (SDR12, SDR25, SDR50, DDR50). Indices 6, 7 and 8 are eMMC legacy, eMMC SDR and eMMC DDR. Reset loads working start-up delays, so the PHY can be used before software changes anything.

A write takes three host writes: first the word with the strobe low, then the same word with the write strobe set, then the word with the strobe cleared. A read uses the same steps with the read strobe. Software polls the acknowledge bit between the steps.

Top module: `phy_delay_port`

## Requirements
- R1: After reset, the access word reads as 0x00000000.
- R2: The access word lives at byte offset 0x10. Host writes to any other offset do not change it. Host reads of any other offset return 0.
- R3: The access word reads back as follows. Bits [7:0] hold the register index. Bits [11:8] hold the low nibble of the write byte, which occupies bits [15:8] when written. Bits [19:12] hold the last read result. Bit 24 is the write strobe, bit 25 the read strobe and bit 26 the acknowledge. All other bits read 0.
- R4: A 0-to-1 transition of bit 24 stores write byte [15:8] into the delay register selected by [7:0]. Writing the word while bit 24 is 0 never changes a delay register.
- R5: While bit 24 stays at 1, further host writes to the word do not store anything, even if the index or write byte changes.
- R6: A 0-to-1 transition of bit 25 copies the selected delay register into bits [19:12]. The new value is visible one clock after the host write that set the strobe, and it stays until the next read strobe.
- R7: The acknowledge bit 26 reads 0 right after the strobe-setting write and reads 1 one clock later. It stays 1 while either strobe is 1. It returns to 0 one clock after a host write that leaves both strobes at 0.
- R8: An index above 8 leaves every delay register unchanged on a write, returns 0 in [19:12] on a read, and still raises the acknowledge.
- R9: Reset values of the delay registers: index 0 = 4, 1 = 4, 6 = 9, 7 = 2, 8 = 3, and indices 2 to 5 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostSel | input | 1 | Host access valid this cycle |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 8 | Host byte offset |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Host read data, combinational |

## Verification
A wrong strobe-history bit shows at the ports as a missed store or a repeated store. The bench sees it at the next read-back of that index, and the acknowledge bit also reads wrong one clock after the strobe write. A corrupted delay register or a bad index decode shows up in the sweep over all sixteen low indices, which checks every register against its reset value, then against a computed write pattern, and checks that the out-of-range indices read 0. A stuck acknowledge is caught one clock after the clearing write.

// File: rtl/phy_port_pkg.sv
package phy_port_pkg;
  localparam int PHY_DATA_W   = 8;
  localparam int PHY_ADDR_W   = 8;
  localparam int PHY_NUM_REGS = 9;
  // access word bit positions (decoded by software)
  localparam int WDATA_LSB = 8;
  localparam int RDATA_LSB = 12;
  localparam int WR_BIT    = 24;
  localparam int RD_BIT    = 25;
  localparam int ACK_BIT   = 26;

  typedef struct packed {
    logic commit;   // store write byte into file
    logic capture;  // copy file entry into read field
  } phyStrobe_t;

  function automatic logic [PHY_DATA_W-1:0] resetValue(int idx);
    case (idx)
      0, 1:    return PHY_DATA_W'(4);
      6:       return PHY_DATA_W'(9);
      7:       return PHY_DATA_W'(2);
      8:       return PHY_DATA_W'(3);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/phy_port_ctrl.sv
module phy_port_ctrl
  import phy_port_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrLvl,
  input  logic       rdLvl,
  output phyStrobe_t strb,
  output logic       ack
);
  logic wrPrev, rdPrev;

  assign strb.commit  = wrLvl & ~wrPrev;
  assign strb.capture = rdLvl & ~rdPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPrev <= 1'b0;
      rdPrev <= 1'b0;
      ack    <= 1'b0;
    end else begin
      wrPrev <= wrLvl;
      rdPrev <= rdLvl;
      ack    <= (ack | strb.commit | strb.capture) & (wrLvl | rdLvl);
    end
  end
endmodule

// File: rtl/phy_port_dpath.sv
module phy_port_dpath
  import phy_port_pkg::*;
#(
  parameter int ADDR_W   = PHY_ADDR_W,
  parameter int DATA_W   = PHY_DATA_W,
  parameter int NUM_REGS = PHY_NUM_REGS,
  localparam int FILE_W  = NUM_REGS * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wordWe,
  input  logic [31:0]       wordIn,
  input  phyStrobe_t        strb,
  input  logic              ack,
  output logic [31:0]       wordOut,
  output logic              wrLvl,
  output logic              rdLvl,
  output logic [ADDR_W-1:0] addrQ,
  output logic [DATA_W-1:0] wdataQ,
  output logic [DATA_W-1:0] rdDataQ,
  output logic [FILE_W-1:0] fileFlat
);
  logic [DATA_W-1:0] delayReg [NUM_REGS];
  logic [DATA_W-1:0] picked;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      wrLvl  <= 1'b0;
      rdLvl  <= 1'b0;
    end else if (wordWe) begin
      addrQ  <= wordIn[ADDR_W-1:0];
      wdataQ <= wordIn[WDATA_LSB +: DATA_W];
      wrLvl  <= wordIn[WR_BIT];
      rdLvl  <= wordIn[RD_BIT];
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gEntry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        delayReg[g] <= DATA_W'(resetValue(g));
      else if (strb.commit && addrQ == ADDR_W'(g))
        delayReg[g] <= wdataQ;
    end
    assign fileFlat[g*DATA_W +: DATA_W] = delayReg[g];
  end

  // out-of-range index selects nothing and yields zero
  always_comb begin
    picked = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (addrQ == ADDR_W'(i)) picked = delayReg[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rdDataQ <= '0;
    else if (strb.capture) rdDataQ <= picked;
  end

  always_comb begin
    wordOut                         = '0;
    wordOut[ADDR_W-1:0]             = addrQ;
    wordOut[WDATA_LSB +: DATA_W]    = wdataQ;
    wordOut[RDATA_LSB +: DATA_W]    = rdDataQ;  // overlays upper write nibble
    wordOut[WR_BIT]                 = wrLvl;
    wordOut[RD_BIT]                 = rdLvl;
    wordOut[ACK_BIT]                = ack;
  end
endmodule

// File: rtl/phy_delay_port.sv
module phy_delay_port
  import phy_port_pkg::*;
#(
  parameter int HOST_AW          = 8,
  parameter logic [7:0] ACC_OFFSET = 8'h10,
  parameter int NUM_REGS         = PHY_NUM_REGS,
  localparam int FILE_W          = NUM_REGS * PHY_DATA_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostSel,
  input  logic               hostWrite,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [31:0]        hostWdata,
  output logic [31:0]        hostRdata
);
  phyStrobe_t            strb;
  logic                  ack, wrLvl, rdLvl, hit, commitSig, captureSig;
  logic [PHY_ADDR_W-1:0] addrQ;
  logic [PHY_DATA_W-1:0] wdataQ, rdDataQ;
  logic [FILE_W-1:0]     fileFlat;
  logic [31:0]           accWord;
  logic                  unusedHostBits;

  assign hit        = hostSel && (hostAddr == HOST_AW'(ACC_OFFSET));
  assign hostRdata  = (hit && !hostWrite) ? accWord : '0;
  assign commitSig  = strb.commit;
  assign captureSig = strb.capture;
  assign unusedHostBits = ^{hostWdata[31:26], hostWdata[23:16]};

  phy_port_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrLvl(wrLvl), .rdLvl(rdLvl),
    .strb(strb), .ack(ack)
  );

  phy_port_dpath #(.NUM_REGS(NUM_REGS)) u_dpath (
    .clk(clk), .rstN(rstN), .wordWe(hit && hostWrite), .wordIn(hostWdata),
    .strb(strb), .ack(ack), .wordOut(accWord), .wrLvl(wrLvl), .rdLvl(rdLvl),
    .addrQ(addrQ), .wdataQ(wdataQ), .rdDataQ(rdDataQ), .fileFlat(fileFlat)
  );
endmodule

// File: rtl/phy_delay_port_chk.sv
module phy_delay_port_chk
  import phy_port_pkg::*;
#(
  parameter int NUM_REGS = PHY_NUM_REGS,
  localparam int FILE_W  = NUM_REGS * PHY_DATA_W
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  wrLvl,
  input logic                  rdLvl,
  input logic                  ack,
  input logic                  commitSig,
  input logic                  captureSig,
  input logic [PHY_ADDR_W-1:0] addrQ,
  input logic [PHY_DATA_W-1:0] wdataQ,
  input logic [PHY_DATA_W-1:0] rdDataQ,
  input logic [FILE_W-1:0]     fileFlat
);
  function automatic logic [PHY_DATA_W-1:0] entryOf(logic [FILE_W-1:0] f, logic [PHY_ADDR_W-1:0] idx);
    logic [PHY_DATA_W-1:0] r;
    r = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (idx == PHY_ADDR_W'(i)) r = f[i*PHY_DATA_W +: PHY_DATA_W];
    return r;
  endfunction

  logic inRange;
  assign inRange = addrQ < PHY_ADDR_W'(NUM_REGS);

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    (commitSig && inRange) |=> entryOf(fileFlat, $past(addrQ)) == $past(wdataQ)); // R4
  AST_SINGLE_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    commitSig |=> !commitSig); // R5
  AST_READ_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    captureSig |=> rdDataQ == $past(entryOf(fileFlat, addrQ))); // R6
  AST_ACK_RISES: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(wrLvl) || $rose(rdLvl)) |=> ack); // R7
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (!wrLvl && !rdLvl) |=> !ack); // R7
  AST_OOR_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (commitSig && !inRange) |=> $stable(fileFlat)); // R8
  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (captureSig && !inRange) |=> rdDataQ == '0); // R8
endmodule

bind phy_delay_port phy_delay_port_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rstN(rstN), .wrLvl(wrLvl), .rdLvl(rdLvl), .ack(ack),
  .commitSig(commitSig), .captureSig(captureSig), .addrQ(addrQ),
  .wdataQ(wdataQ), .rdDataQ(rdDataQ), .fileFlat(fileFlat)
);

// File: tb/phy_delay_port_bench.sv
`timescale 1ns/100ps
module phy_delay_port_bench;
  localparam logic [31:0] WR = 32'h0100_0000;
  localparam logic [31:0] RD = 32'h0200_0000;
  localparam logic [31:0] AK = 32'h0400_0000;

  logic clk = 1'b0, rstN = 1'b0, hostSel = 1'b0, hostWrite = 1'b0;
  logic [7:0]  hostAddr = '0;
  logic [31:0] hostWdata = '0, hostRdata;
  int checks = 0, fails = 0;
  logic [7:0] lastRd = '0;
  logic [7:0] model [16];
  bit done = 0;

  always #2.5 clk = ~clk;

  phy_delay_port u_phy_delay_port (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWrite(hostWrite),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic hostWr(logic [7:0] off, logic [31:0] d);
    @(negedge clk);
    hostSel = 1; hostWrite = 1; hostAddr = off; hostWdata = d;
    @(negedge clk);
    hostSel = 0; hostWrite = 0;
  endtask

  task automatic hostRd(logic [7:0] off, output logic [31:0] v);
    hostSel = 1; hostWrite = 0; hostAddr = off;
    #0.5 v = hostRdata;
    hostSel = 0;
  endtask

  function automatic logic [31:0] word(logic [7:0] a, logic [7:0] d, logic [7:0] r);
    return {24'h0, a} | ({28'h0, d[3:0]} << 8) | ({24'h0, r} << 12);
  endfunction

  task automatic readReg(logic [7:0] a, logic [7:0] exp, string req);
    logic [31:0] v;
    hostWr(8'h10, {24'h0, a} | RD);
    hostRd(8'h10, v);
    check("R7 ack low before clock", v, word(a, 0, lastRd) | RD);
    @(negedge clk);
    hostRd(8'h10, v);
    check(req, v, word(a, 0, exp) | RD | AK);
    lastRd = exp;
    hostWr(8'h10, {24'h0, a});
    hostRd(8'h10, v);
    check("R7 ack held until cleared", v, word(a, 0, exp) | AK);
    @(negedge clk);
    hostRd(8'h10, v);
    check("R7 ack dropped", v, word(a, 0, exp));
  endtask

  task automatic writeReg(logic [7:0] a, logic [7:0] d);
    logic [31:0] base;
    base = {24'h0, a} | ({24'h0, d} << 8);
    hostWr(8'h10, base);
    hostWr(8'h10, base | WR);
    @(negedge clk);
    hostWr(8'h10, base);
    @(negedge clk);
    if (a < 9) model[a] = d;
  endtask

  initial begin
    #(5.0 * 20000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    model[0] = 4; model[1] = 4; model[6] = 9; model[7] = 2; model[8] = 3;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    hostRd(8'h10, v); check("R1 reset word", v, 32'h0);
    hostRd(8'h14, v); check("R2 other offset read", v, 32'h0);

    // R9 / R8: reset values over all low indices
    for (int a = 0; a < 16; a++) readReg(8'(a), model[a], "R9 reset value");

    // R3: field layout without strobes
    hostWr(8'h10, 32'h0000_A507);
    hostRd(8'h10, v); check("R3 field layout", v, word(8'h07, 8'hA5, lastRd));

    // R4 / R8: write sweep then read sweep
    for (int a = 0; a < 16; a++) writeReg(8'(a), 8'((a * 13 + 7) & 8'hFF));
    for (int a = 0; a < 16; a++)
      readReg(8'(a), model[a], a < 9 ? "R4 stored value" : "R8 out-of-range read");

    // R4: strobe low never stores
    hostWr(8'h10, 32'h0000_AA02);
    @(negedge clk);
    readReg(8'h02, model[2], "R4 no store without strobe");

    // R5: data change with strobe held high
    hostWr(8'h10, 32'h0000_1103);
    hostWr(8'h10, 32'h0000_1103 | WR);
    @(negedge clk);
    hostWr(8'h10, 32'h0000_2203 | WR);
    @(negedge clk);
    hostRd(8'h10, v); check("R7 ack stays with strobe held", v & AK, AK);
    hostWr(8'h10, 32'h0000_2203);
    @(negedge clk);
    model[3] = 8'h11;
    readReg(8'h03, 8'h11, "R5 single store per edge");

    // R2: write at another offset leaves the access word alone
    hostWr(8'h14, 32'h0000_5505 | WR);
    hostRd(8'h10, v); check("R2 other offset write", v, word(8'h03, 0, lastRd));
    @(negedge clk);
    readReg(8'h05, model[5], "R2 no store via other offset");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule